// File: doc/BRIEF.md
# I2C Byte Master

This block is a single-master I2C engine that moves one byte at a time. Software controls it through five byte-wide registers: a control register, a status register, an interrupt-enable register, a target register and a data port. Software writes a 7-bit target and a direction into the target register. It then sets the enable and go bits. The engine sends a START and the target byte, then shifts data bytes out of, or into, the data port. A one-byte holding buffer sits ahead of the shift register on the write side, so the next byte can be loaded while the current one is on the wire.

Bus timing comes from outside. A one-cycle `tick_i` strobe marks every quarter of an SCL period, and the engine spends four strobes on each bit. Both bus lines are open-drain and are modelled as pull-low enables. Between bytes the engine holds SCL low and waits for the buffer, the receive flag or a stop request. The status register collects seven events, and any status bit whose enable bit is set drives the single interrupt line.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset every register reads 0x00, `irq_o` is 0 and both line enables (`scl_oe_o`, `sda_oe_o`) are 0.
- R2: The register offsets are control 0, status 1, interrupt enable 2, target 3 and data 4. The target register holds the 7-bit address in bits 7:1 and the direction in bit 0, where 1 means read. After the START, the byte on the bus is exactly the target register.
- R3: Control bit 0 is enable, bit 1 is go and bit 2 is stop. When enable and go are both 1, the engine issues START and the target byte, clears go by itself, and sets status bit 0 (address done) when that byte ends. Go without enable causes no bus activity and no status change.
- R4: In a write transfer, each data-port byte moves into the shift register when the engine needs it. Each move sets status bit 1 (buffer empty). Bytes appear on the bus in the order they were written, and each byte the target ACKs sets status bit 2 (byte sent).
- R5: A stop request takes effect at the next byte boundary. It beats a byte still waiting in the buffer, which is not sent. The engine then produces a STOP, sets status bit 6 (stop sent) and clears the stop bit.
- R6: In a read transfer, each received byte is ACKed, latched into the data port and flagged in status bit 3 (byte received). The engine holds SCL low and starts no further byte while status bit 3 is still 1.
- R7: If stop is requested before the acknowledge slot of a read byte, that byte is answered with a NACK, latched, flagged in status bit 3, and followed by a STOP.
- R8: A NACK on the target byte or on a data byte sets status bit 4. The engine then holds SCL low and generates no STOP until a stop is requested.
- R9: When the engine drives a 1 on a target or data bit and reads 0, it sets status bit 5 (arbitration lost), releases both lines at once and returns to idle without a STOP.
- R10: A status write clears each bit written as 0 and keeps each bit written as 1. An event raised in the same cycle still sets its bit.
- R11: `irq_o` is 1 exactly when some status bit and the interrupt-enable bit in the same position are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Quarter-SCL-period strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| irq_o | output | 1 | Interrupt request |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sensed SDA level |

## Verification
The assertions assume the following about the inputs:
- `tick_i` is a single-cycle strobe.
- The bus only changes SDA while SCL is low, except where the engine itself makes START and STOP.
- Software does not write the go bit while a transfer is running.

The bench satisfies all three. It raises `tick_i` once every four clocks. Its target model changes SDA only on SCL falling edges. It issues go only from idle. To provoke arbitration loss, it holds SDA low from before the START. This keeps the stimulus inside the assumed bus behaviour and still forces a 1-versus-0 mismatch on the first address bit.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam int BCNT_W = $clog2(BYTE_W + 1);
  localparam int REG_AW = 3;
  localparam int NSTAT  = 7;

  localparam logic [REG_AW-1:0] OFS_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] OFS_STAT = 3'd1;
  localparam logic [REG_AW-1:0] OFS_IEN  = 3'd2;
  localparam logic [REG_AW-1:0] OFS_TGT  = 3'd3;
  localparam logic [REG_AW-1:0] OFS_DATA = 3'd4;

  localparam int CB_EN   = 0;
  localparam int CB_GO   = 1;
  localparam int CB_STOP = 2;

  localparam int SB_ADDR  = 0;
  localparam int SB_EMPTY = 1;
  localparam int SB_SENT  = 2;
  localparam int SB_RCVD  = 3;
  localparam int SB_NACK  = 4;
  localparam int SB_ARB   = 5;
  localparam int SB_STOP  = 6;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BYTE, S_HOLD, S_STOP} eng_state_e;
  typedef enum logic [1:0] {K_ADDR, K_TX, K_RX} byte_kind_e;
endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              en_o,
  output logic              go_o,
  output logic              stop_o,
  output logic [BYTE_W-1:0] tgt_o,
  output logic [BYTE_W-1:0] txd_o,
  output logic              tx_full_o,
  output logic              rx_stat_o,
  input  logic              go_ack_i,
  input  logic              stop_ack_i,
  input  logic              load_i,
  input  logic [NSTAT-1:0]  ev_i,
  input  logic [BYTE_W-1:0] rxd_i,
  output logic              irq_o
);
  logic              en_q, go_q, stop_q, full_q;
  logic [NSTAT-1:0]  stat_q, ien_q, stat_nx;
  logic [BYTE_W-1:0] tgt_q, txd_q, rxd_q;
  logic wr_ctrl, wr_stat, wr_ien, wr_tgt, wr_data;

  assign wr_ctrl = we_i && (addr_i == OFS_CTRL);
  assign wr_stat = we_i && (addr_i == OFS_STAT);
  assign wr_ien  = we_i && (addr_i == OFS_IEN);
  assign wr_tgt  = we_i && (addr_i == OFS_TGT);
  assign wr_data = we_i && (addr_i == OFS_DATA);

  // zero-written bits clear, events set last so they win
  always_comb begin
    stat_nx = wr_stat ? (stat_q & wdata_i[NSTAT-1:0]) : stat_q;
    stat_nx = stat_nx | ev_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      go_q   <= 1'b0;
      stop_q <= 1'b0;
      full_q <= 1'b0;
      stat_q <= '0;
      ien_q  <= '0;
      tgt_q  <= '0;
      txd_q  <= '0;
      rxd_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata_i[CB_EN];
        go_q   <= wdata_i[CB_GO];
        stop_q <= wdata_i[CB_STOP];
      end
      if (go_ack_i)   go_q   <= 1'b0;
      if (stop_ack_i) stop_q <= 1'b0;
      stat_q <= stat_nx;
      if (wr_ien) ien_q <= wdata_i[NSTAT-1:0];
      if (wr_tgt) tgt_q <= wdata_i;
      if (wr_data) begin
        txd_q  <= wdata_i;
        full_q <= 1'b1;
      end else if (load_i) begin
        full_q <= 1'b0;
      end
      if (ev_i[SB_RCVD]) rxd_q <= rxd_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CTRL: begin
        rdata_o[CB_EN]   = en_q;
        rdata_o[CB_GO]   = go_q;
        rdata_o[CB_STOP] = stop_q;
      end
      OFS_STAT: rdata_o[NSTAT-1:0] = stat_q;
      OFS_IEN:  rdata_o[NSTAT-1:0] = ien_q;
      OFS_TGT:  rdata_o = tgt_q;
      OFS_DATA: rdata_o = rxd_q;
      default:  rdata_o = '0;
    endcase
  end

  assign en_o      = en_q;
  assign go_o      = go_q;
  assign stop_o    = stop_q;
  assign tgt_o     = tgt_q;
  assign txd_o     = txd_q;
  assign tx_full_o = full_q;
  assign rx_stat_o = stat_q[SB_RCVD];
  assign irq_o     = |(stat_q & ien_q);

  assert_go_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_ack_i |=> !go_q);
  assert_stat_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_stat && ev_i == '0) |=> $stable(stat_q));
  assert_empty_on_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> stat_q[SB_EMPTY]);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              go_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] tgt_i,
  input  logic [BYTE_W-1:0] txd_i,
  input  logic              tx_full_i,
  input  logic              rx_stat_i,
  output logic              go_ack_o,
  output logic              stop_ack_o,
  output logic              load_o,
  output logic [NSTAT-1:0]  ev_o,
  output logic [BYTE_W-1:0] rxd_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  localparam logic [BCNT_W-1:0] ACK_SLOT = BCNT_W'(BYTE_W);

  eng_state_e        state_q, state_d;
  byte_kind_e        kind_q, kind_d;
  logic [1:0]        ph_q, ph_d;
  logic [BCNT_W-1:0] bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic rd_q, rd_d, nacked_q, nacked_d, last_q, last_d, ack_q, ack_d;
  logic scl_q, scl_d, sda_q, sda_d;

  always_comb begin
    state_d = state_q; kind_d = kind_q; ph_d = ph_q; bit_d = bit_q; sh_d = sh_q;
    rd_d = rd_q; nacked_d = nacked_q; last_d = last_q; ack_d = ack_q;
    scl_d = scl_q; sda_d = sda_q;
    go_ack_o = 1'b0; stop_ack_o = 1'b0; load_o = 1'b0; ev_o = '0;
    case (state_q)
      S_IDLE: begin
        if (en_i && go_i) begin
          go_ack_o = 1'b1;
          state_d  = S_START;
          ph_d     = 2'd0;
          sh_d     = tgt_i;
          rd_d     = tgt_i[0];
          kind_d   = K_ADDR;
          nacked_d = 1'b0;
          last_d   = 1'b0;
        end
      end
      S_START: if (tick_i) begin
        ph_d = ph_q + 2'd1;
        case (ph_q)
          2'd0: sda_d = 1'b1;
          2'd2: scl_d = 1'b1;
          2'd3: begin state_d = S_BYTE; bit_d = '0; end
          default: ;
        endcase
      end
      S_BYTE: if (tick_i) begin
        ph_d = ph_q + 2'd1;
        case (ph_q)
          2'd0: begin
            if (bit_q != ACK_SLOT) begin
              sda_d = (kind_q == K_RX) ? 1'b0 : !sh_q[BYTE_W-1];
            end else if (kind_q == K_RX) begin
              sda_d  = !stop_i;   // stop pending: answer NACK
              last_d = stop_i;
            end else begin
              sda_d = 1'b0;
            end
          end
          2'd1: scl_d = 1'b0;
          2'd2: begin
            if (bit_q != ACK_SLOT) begin
              sh_d = {sh_q[BYTE_W-2:0], sda_i};
              if (kind_q != K_RX && sh_q[BYTE_W-1] && !sda_i) begin
                ev_o[SB_ARB] = 1'b1;
                stop_ack_o   = 1'b1;
                scl_d        = 1'b0;
                sda_d        = 1'b0;
                state_d      = S_IDLE;
                ph_d         = 2'd0;
              end
            end else begin
              ack_d = !sda_i;
            end
          end
          default: begin
            scl_d = 1'b1;
            if (bit_q == ACK_SLOT) begin
              state_d = S_HOLD;
              case (kind_q)
                K_ADDR: begin
                  ev_o[SB_ADDR] = 1'b1;
                  kind_d = rd_q ? K_RX : K_TX;
                  if (!ack_q) begin ev_o[SB_NACK] = 1'b1; nacked_d = 1'b1; end
                end
                K_TX: begin
                  if (ack_q) ev_o[SB_SENT] = 1'b1;
                  else begin ev_o[SB_NACK] = 1'b1; nacked_d = 1'b1; end
                end
                default: ev_o[SB_RCVD] = 1'b1;
              endcase
            end else begin
              bit_d = bit_q + BCNT_W'(1);
            end
          end
        endcase
      end
      S_HOLD: begin
        if (nacked_q) begin
          if (stop_i) begin state_d = S_STOP; ph_d = 2'd0; end
        end else if (kind_q == K_RX) begin
          if (last_q) begin
            state_d = S_STOP; ph_d = 2'd0;
          end else if (!rx_stat_i) begin
            state_d = S_BYTE; ph_d = 2'd0; bit_d = '0;
          end
        end else if (stop_i) begin
          state_d = S_STOP; ph_d = 2'd0;
        end else if (tx_full_i) begin
          load_o          = 1'b1;
          ev_o[SB_EMPTY]  = 1'b1;
          sh_d            = txd_i;
          state_d         = S_BYTE; ph_d = 2'd0; bit_d = '0;
        end
      end
      S_STOP: if (tick_i) begin
        ph_d = ph_q + 2'd1;
        case (ph_q)
          2'd0: sda_d = 1'b1;
          2'd1: scl_d = 1'b0;
          2'd2: sda_d = 1'b0;
          default: begin
            state_d       = S_IDLE;
            ev_o[SB_STOP] = 1'b1;
            stop_ack_o    = 1'b1;
          end
        endcase
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; kind_q <= K_ADDR; ph_q <= '0; bit_q <= '0; sh_q <= '0;
      rd_q <= 1'b0; nacked_q <= 1'b0; last_q <= 1'b0; ack_q <= 1'b0;
      scl_q <= 1'b0; sda_q <= 1'b0;
    end else begin
      state_q <= state_d; kind_q <= kind_d; ph_q <= ph_d; bit_q <= bit_d; sh_q <= sh_d;
      rd_q <= rd_d; nacked_q <= nacked_d; last_q <= last_d; ack_q <= ack_d;
      scl_q <= scl_d; sda_q <= sda_d;
    end
  end

  assign rxd_o    = sh_q;
  assign scl_oe_o = scl_q;
  assign sda_oe_o = sda_q;

  assert_idle_scl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |-> !scl_oe_o);
  assert_arb_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o[SB_ARB] |=> (!scl_oe_o && !sda_oe_o && state_q == S_IDLE));
  assert_nack_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HOLD && nacked_q && !stop_i) |=> (state_q == S_HOLD && scl_oe_o));
  assert_rx_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HOLD && kind_q == K_RX && !nacked_q && !last_q && rx_stat_i)
      |=> (state_q == S_HOLD));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  logic              en, go, stop, tx_full, rx_stat, go_ack, stop_ack, load;
  logic [BYTE_W-1:0] tgt, txd, rxd;
  logic [NSTAT-1:0]  ev;

  i2cm_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .en_o       (en),
    .go_o       (go),
    .stop_o     (stop),
    .tgt_o      (tgt),
    .txd_o      (txd),
    .tx_full_o  (tx_full),
    .rx_stat_o  (rx_stat),
    .go_ack_i   (go_ack),
    .stop_ack_i (stop_ack),
    .load_i     (load),
    .ev_i       (ev),
    .rxd_i      (rxd),
    .irq_o      (irq_o)
  );

  i2cm_engine u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .en_i       (en),
    .go_i       (go),
    .stop_i     (stop),
    .tgt_i      (tgt),
    .txd_i      (txd),
    .tx_full_i  (tx_full),
    .rx_stat_i  (rx_stat),
    .go_ack_o   (go_ack),
    .stop_ack_o (stop_ack),
    .load_o     (load),
    .ev_o       (ev),
    .rxd_o      (rxd),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o),
    .sda_i      (sda_i)
  );
endmodule

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic [1:0] tdiv;
  logic       we = 1'b0;
  logic [2:0] ra = 3'd0;
  logic [7:0] wd = 8'd0;
  logic [7:0] rdv;
  logic       irq, scl_oe, sda_oe, sda_bus;
  logic       slv_low = 1'b0;
  logic       ext_low = 1'b0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tdiv <= '0; else tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);
  assign sda_bus = !(sda_oe | slv_low | ext_low);

  i2c_byte_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .reg_we_i(we), .reg_addr_i(ra), .reg_wdata_i(wd), .reg_rdata_o(rdv),
    .irq_o(irq), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_bus)
  );

  // target model
  logic [6:0] slv_addr = 7'h52;
  logic [7:0] sbyte = 8'h00, addr_seen = 8'h00;
  logic [7:0] log_b [0:7];
  logic [7:0] rd_src [0:7];
  logic       macks [0:7];
  int bcnt = 0, log_n = 0, rd_i = 0, mack_n = 0, nack_from = 100, stop_cnt = 0;
  bit active = 1'b0, in_addr = 1'b0, rw = 1'b0, prev_scl = 1'b1, prev_sda = 1'b1;

  always @(negedge clk) begin
    bit cs, cd;
    cs = !scl_oe;
    cd = sda_bus;
    if (cs && prev_scl && prev_sda && !cd) begin
      active = 1; bcnt = 0; in_addr = 1; slv_low = 0;
    end else if (cs && prev_scl && !prev_sda && cd) begin
      active = 0; stop_cnt++; slv_low = 0;
    end else if (active && cs && !prev_scl) begin
      if (bcnt < 8) sbyte = {sbyte[6:0], cd};
      else if (!in_addr && rw) begin macks[mack_n] = !cd; mack_n++; end
      bcnt++;
    end else if (active && !cs && prev_scl) begin
      if (bcnt == 8) begin
        if (in_addr) begin
          addr_seen = sbyte; rw = sbyte[0];
          slv_low = (sbyte[7:1] == slv_addr);
          if (!slv_low) active = 0;
        end else if (!rw) begin
          log_b[log_n] = sbyte; slv_low = (log_n < nack_from); log_n++;
        end else slv_low = 0;
      end else if (bcnt == 9) begin
        bcnt = 0;
        if (in_addr) begin
          in_addr = 0;
          slv_low = rw ? !rd_src[rd_i][7] : 1'b0;
        end else if (rw) begin
          if (macks[mack_n-1]) begin rd_i++; slv_low = !rd_src[rd_i][7]; end
          else begin slv_low = 0; active = 0; end
        end else slv_low = 0;
      end else if (rw && !in_addr && bcnt >= 1 && bcnt <= 7) begin
        slv_low = !rd_src[rd_i][7-bcnt];
      end
    end
    prev_scl = cs; prev_sda = cd;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; ra = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); ra = a; #1; d = rdv;
  endtask

  task automatic wait_bit(input int b, input int lim, input string req);
    logic [7:0] s;
    bit seen = 1'b0;
    for (int n = 0; n < lim && !seen; n++) begin
      rd(3'd1, s);
      seen = s[b];
    end
    chk(req, int'(seen), 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 reg reset", d, 0);
    end
    chk("R1 irq reset", irq, 0);
    chk("R1 lines reset", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_no_enable;
    logic [7:0] d;
    wr(3'd3, 8'hA4);
    wr(3'd0, 8'h02);
    idle(60);
    chk("R3 no bus without enable", {scl_oe, sda_oe}, 0);
    rd(3'd1, d);
    chk("R3 no status without enable", d, 0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_write;
    logic [7:0] d;
    log_n = 0; nack_from = 100;
    wr(3'd3, 8'hA4);
    wr(3'd4, 8'h3C);
    wr(3'd0, 8'h03);
    idle(3);
    rd(3'd0, d);
    chk("R3 go self-clears", d, 8'h01);
    wait_bit(1, 400, "R4 first buffer empty");
    rd(3'd1, d);
    chk("R3 address done with empty", d, 8'h03);
    wr(3'd1, 8'hFD);
    rd(3'd1, d);
    chk("R10 zero clears only its bit", d, 8'h01);
    wr(3'd4, 8'hC5);
    wait_bit(1, 400, "R4 second buffer empty");
    wr(3'd4, 8'h77);
    wr(3'd0, 8'h05);
    wait_bit(6, 600, "R5 stop sent");
    chk("R2 address byte on bus", addr_seen, 8'hA4);
    chk("R4 byte count", log_n, 2);
    chk("R4 first byte", log_b[0], 8'h3C);
    chk("R4 second byte", log_b[1], 8'hC5);
    rd(3'd1, d);
    chk("R4 status sent no nack", d & 8'h14, 8'h04);
    rd(3'd0, d);
    chk("R5 stop bit self-clears", d, 8'h01);
    chk("R5 one stop on bus", stop_cnt, 1);
  endtask

  task automatic t_irq;
    // status holds addr|empty|sent|stop = 0x47
    wr(3'd2, 8'h00); idle(1);
    chk("R11 irq off when masked", irq, 0);
    wr(3'd2, 8'h40); idle(1);
    chk("R11 irq on enabled stop", irq, 1);
    wr(3'd2, 8'h08); idle(1);
    chk("R11 irq off for clear bit", irq, 0);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] d;
    wr(3'd1, 8'hFF);
    rd(3'd1, d);
    chk("R10 ones keep", d, 8'h47);
    wr(3'd1, 8'hBF);
    rd(3'd1, d);
    chk("R10 clear stop only", d, 8'h07);
    wr(3'd1, 8'h00);
    rd(3'd1, d);
    chk("R10 clear all", d, 8'h00);
  endtask

  task automatic t_read;
    logic [7:0] d;
    rd_src[0] = 8'h81; rd_src[1] = 8'h5A; rd_src[2] = 8'hE7; rd_src[3] = 8'hFF;
    rd_i = 0; mack_n = 0;
    wr(3'd3, 8'hA5);
    wr(3'd0, 8'h03);
    wait_bit(3, 600, "R6 first byte received");
    rd(3'd4, d);
    chk("R6 first data", d, 8'h81);
    idle(300);
    chk("R6 scl held while flag set", scl_oe, 1);
    chk("R6 no further ack while held", mack_n, 1);
    wr(3'd1, 8'hF7);
    wait_bit(3, 600, "R6 second byte received");
    rd(3'd4, d);
    chk("R6 second data", d, 8'h5A);
    wr(3'd0, 8'h05);
    wr(3'd1, 8'hF7);
    wait_bit(6, 800, "R7 stop after last read");
    rd(3'd4, d);
    chk("R7 last data latched", d, 8'hE7);
    chk("R7 ack count", mack_n, 3);
    chk("R6 first acked", macks[0], 1);
    chk("R7 last nacked", macks[2], 0);
    rd(3'd1, d);
    chk("R7 received flag set", d[3], 1);
  endtask

  task automatic t_nack;
    logic [7:0] d;
    int s0;
    wr(3'd1, 8'h00);
    s0 = stop_cnt;
    wr(3'd3, 8'h20);
    wr(3'd0, 8'h03);
    wait_bit(4, 400, "R8 nack flagged");
    idle(200);
    chk("R8 scl held after nack", scl_oe, 1);
    rd(3'd1, d);
    chk("R8 no stop yet, address done", d & 8'h41, 8'h01);
    chk("R8 no stop on bus yet", stop_cnt, s0);
    wr(3'd0, 8'h05);
    wait_bit(6, 200, "R8 stop after request");
    chk("R8 stop on bus", stop_cnt, s0 + 1);
  endtask

  task automatic t_arb;
    logic [7:0] d;
    wr(3'd1, 8'h00);
    ext_low = 1'b1;
    wr(3'd3, 8'hA4);
    wr(3'd0, 8'h03);
    wait_bit(5, 200, "R9 arbitration lost");
    idle(40);
    chk("R9 lines released", {scl_oe, sda_oe}, 0);
    rd(3'd1, d);
    chk("R9 no stop, no address done", d & 8'h41, 8'h00);
    ext_low = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_no_enable;
    t_write;
    t_irq;
    t_status;
    t_read;
    t_nack;
    t_arb;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule